// File: doc/BRIEF.md
# Single-Level Interrupt and Halt Sequencer

This block steers program flow for a small 4-bit processor core. It owns the 12-bit program counter, a one-entry return stack that holds a return address plus a saved carry, the global interrupt enable, the timer and wake interrupts, and the halt state. The instruction decoder presents one retiring instruction per cycle as a strobe plus an operation code, the instruction length and a target address. The block answers with the next fetch address, whose top bit is the bank bit supplied from outside.

There is only one stack entry. Every interrupt therefore waits until the stack is empty and interrupts are enabled. Interrupts are taken only in cycles in which no instruction retires, and taking one pushes both the current PC and the carry. A subroutine call pushes only its return address. While halted, the core clock is considered stopped. A falling edge on an enabled input pin ends the halt, and if interrupts are enabled, that edge also raises a wake interrupt that vectors to offset 8 in the current bank.

Top module: `psq_flow_ctl`

## Requirements
- R1: While reset is held and after it is released, PC is 000h, the stack is empty, the core is not halted and interrupts are disabled. The fetch address is {bank_i, PC}, so with bank_i=1 it reads 1000h, and a pending timer flag is not accepted.
- R2: A retiring sequential instruction (op_i=0) advances PC by 2 when len2_i=1 and by 1 otherwise, wrapping modulo 4096.
- R3: A retiring jump (op_i=1) loads all 12 PC bits from tgt_i. A retiring taken conditional branch (op_i=2) replaces PC bits 10..0 with tgt_i[10:0] and keeps PC bit 11.
- R4: A retiring call (op_i=3) stores PC+2 in the stack, marks the stack busy and loads PC from tgt_i. A retiring return (op_i=4) reloads PC from the stack, frees the stack and does not raise carry_ld_o.
- R5: A retiring interrupt return (op_i=5) reloads PC from the stack, frees it and raises carry_ld_o in that cycle, with the saved carry on stk_c_o.
- R6: An interrupt is accepted only in a cycle with retire_i low, interrupts enabled, stack empty and not halted. A request blocked by a busy stack or by disabled interrupts stays pending and is taken after the return (op_i=4) or after enable (op_i=6). Disable is op_i=7.
- R7: A timer interrupt pulses tmr_ack_o for one cycle, pushes PC and carry_i, and sets PC to 004h, keeping the bank bit.
- R8: A retiring halt (op_i=8) advances PC like a sequential instruction and then raises clk_stop_o. While halted, retiring instructions and the timer flag have no effect.
- R9: While halted, a high-to-low transition of pins_i[k] with wake_en_i[k]=1 ends the halt. Edges on disabled pins and rising edges do not. With interrupts disabled, execution resumes at the PC after the halt and no wake interrupt follows.
- R10: A wake with interrupts enabled latches a wake request. When it is taken it pulses ext_ack_o, pushes PC and carry, sets PC to 008h and clears the request.
- R11: When timer and wake requests are both pending, the timer is taken first, and the wake request is taken once the stack is free again.
- R12: Falling pin edges while not halted produce no wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | An instruction retires this cycle |
| op_i | input | 4 | Flow operation code of the retiring instruction |
| len2_i | input | 1 | Retiring instruction is two bytes long |
| tgt_i | input | 12 | Jump, branch or call target |
| carry_i | input | 1 | Current carry flag |
| tmr_flag_i | input | 1 | Timer overflow flag (request) |
| pins_i | input | 8 | Input port pins |
| wake_en_i | input | 8 | Per-pin wake source enable |
| bank_i | input | 1 | Program bank bit |
| fetch_addr_o | output | 13 | Fetch address {bank, PC} |
| pc_o | output | 12 | Program counter |
| stk_pc_o | output | 12 | Stacked return address |
| stk_c_o | output | 1 | Stacked carry |
| stk_busy_o | output | 1 | Stack entry in use |
| carry_ld_o | output | 1 | Restore carry from stk_c_o this cycle |
| clk_stop_o | output | 1 | Core clock stopped (halted) |
| tmr_ack_o | output | 1 | Timer interrupt taken; clear flag |
| ext_ack_o | output | 1 | Wake interrupt taken |

## Verification
The bench sweeps sequential advances over mixed lengths up to the 12-bit wrap. A wrong adder width would corrupt the bank or fail to wrap. Conditional branches are tried on both halves of the 2K split; a design that overwrote bit 11 would jump to the wrong half. The bench holds timer requests inside a call and under disable, and then releases them through return and enable. A design that ignored the busy stack would overwrite the return address. It also drives halt wakes through disabled pins, rising edges, edges outside halt and a simultaneous timer request. These catch wrong wake gating, spurious vectors to offset 8, and the wrong priority order.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [3:0] {
        OP_SEQ   = 4'd0,
        OP_JMP   = 4'd1,
        OP_JCOND = 4'd2,
        OP_CALL  = 4'd3,
        OP_RET   = 4'd4,
        OP_RETI  = 4'd5,
        OP_EI    = 4'd6,
        OP_DI    = 4'd7,
        OP_HALT  = 4'd8
    } flow_op_e;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'd0,
        IRQ_TMR  = 2'd1,
        IRQ_EXT  = 2'd2
    } irq_sel_e;

endpackage

// File: rtl/psq_wake_det.sv
module psq_wake_det #(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pins_i,
    input  logic [PIN_W-1:0] en_i,
    output logic             fall_o
);
    logic [PIN_W-1:0] pins_d, pins_q;
    logic [PIN_W-1:0] drop;

    always_comb begin
        pins_d = pins_i;
        drop   = pins_q & ~pins_i & en_i;
        fall_o = |drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end
endmodule

// File: rtl/psq_irq_arb.sv
module psq_irq_arb
    import psq_pkg::*;
#(
    parameter int PC_W    = 12,
    parameter int TMR_VEC = 4,
    parameter int EXT_VEC = 8
) (
    input  logic            allow_i,
    input  logic            tmr_i,
    input  logic            ext_i,
    output irq_sel_e        sel_o,
    output logic [PC_W-1:0] vec_o
);
    always_comb begin
        sel_o = IRQ_NONE;
        vec_o = '0;
        if (allow_i && tmr_i) begin
            sel_o = IRQ_TMR;
            vec_o = PC_W'(TMR_VEC);
        end else if (allow_i && ext_i) begin
            sel_o = IRQ_EXT;
            vec_o = PC_W'(EXT_VEC);
        end
    end
endmodule

// File: rtl/psq_pc_step.sv
module psq_pc_step #(
    parameter int PC_W = 12
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic            len2_i,
    output logic [PC_W-1:0] next_o,
    output logic [PC_W-1:0] call_ret_o
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);
    localparam logic [PC_W-1:0] TWO = PC_W'(2);

    always_comb begin
        next_o     = pc_i + (len2_i ? TWO : ONE);
        call_ret_o = pc_i + TWO;
    end
endmodule

// File: rtl/psq_flow_ctl.sv
module psq_flow_ctl
    import psq_pkg::*;
#(
    parameter int PC_W    = 12,
    parameter int PIN_W   = 8,
    parameter int TMR_VEC = 4,
    parameter int EXT_VEC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic [3:0]       op_i,
    input  logic             len2_i,
    input  logic [PC_W-1:0]  tgt_i,
    input  logic             carry_i,
    input  logic             tmr_flag_i,
    input  logic [PIN_W-1:0] pins_i,
    input  logic [PIN_W-1:0] wake_en_i,
    input  logic             bank_i,
    output logic [PC_W:0]    fetch_addr_o,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  stk_pc_o,
    output logic             stk_c_o,
    output logic             stk_busy_o,
    output logic             carry_ld_o,
    output logic             clk_stop_o,
    output logic             tmr_ack_o,
    output logic             ext_ack_o
);
    localparam int LOW_W = PC_W - 1;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] spc;
        logic            sc;
        logic            full;
        logic            ie;
        logic            halted;
        logic            ext;
    } flow_st_t;

    flow_st_t st_d, st_q;

    logic            wake;
    logic            allow;
    irq_sel_e        sel;
    logic [PC_W-1:0] vec;
    logic [PC_W-1:0] pc_next;
    logic [PC_W-1:0] pc_call_ret;

    psq_wake_det #(.PIN_W(PIN_W)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .en_i   (wake_en_i),
        .fall_o (wake)
    );

    assign allow = !retire_i && st_q.ie && !st_q.full && !st_q.halted;

    psq_irq_arb #(.PC_W(PC_W), .TMR_VEC(TMR_VEC), .EXT_VEC(EXT_VEC)) u_arb (
        .allow_i (allow),
        .tmr_i   (tmr_flag_i),
        .ext_i   (st_q.ext),
        .sel_o   (sel),
        .vec_o   (vec)
    );

    psq_pc_step #(.PC_W(PC_W)) u_step (
        .pc_i       (st_q.pc),
        .len2_i     (len2_i),
        .next_o     (pc_next),
        .call_ret_o (pc_call_ret)
    );

    always_comb begin
        st_d       = st_q;
        tmr_ack_o  = 1'b0;
        ext_ack_o  = 1'b0;
        carry_ld_o = 1'b0;
        if (st_q.halted) begin
            if (wake) begin
                st_d.halted = 1'b0;
                if (st_q.ie) st_d.ext = 1'b1;
            end
        end else if (retire_i) begin
            case (op_i)
                OP_JMP:   st_d.pc = tgt_i;
                OP_JCOND: st_d.pc = {st_q.pc[PC_W-1], tgt_i[LOW_W-1:0]};
                OP_CALL: begin
                    st_d.spc  = pc_call_ret;
                    st_d.full = 1'b1;
                    st_d.pc   = tgt_i;
                end
                OP_RET: begin
                    st_d.pc   = st_q.spc;
                    st_d.full = 1'b0;
                end
                OP_RETI: begin
                    st_d.pc    = st_q.spc;
                    st_d.full  = 1'b0;
                    carry_ld_o = 1'b1;
                end
                OP_EI: begin
                    st_d.ie = 1'b1;
                    st_d.pc = pc_next;
                end
                OP_DI: begin
                    st_d.ie = 1'b0;
                    st_d.pc = pc_next;
                end
                OP_HALT: begin
                    st_d.halted = 1'b1;
                    st_d.pc     = pc_next;
                end
                default:  st_d.pc = pc_next;
            endcase
        end else if (sel != IRQ_NONE) begin
            st_d.spc  = st_q.pc;
            st_d.sc   = carry_i;
            st_d.full = 1'b1;
            st_d.pc   = vec;
            if (sel == IRQ_TMR) begin
                tmr_ack_o = 1'b1;
            end else begin
                ext_ack_o = 1'b1;
                st_d.ext  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_addr_o = {bank_i, st_q.pc};
    assign pc_o         = st_q.pc;
    assign stk_pc_o     = st_q.spc;
    assign stk_c_o      = st_q.sc;
    assign stk_busy_o   = st_q.full;
    assign clk_stop_o   = st_q.halted;

    AST_TMR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ack_o |=> (pc_o == PC_W'(TMR_VEC)) && stk_busy_o); // R7

    AST_EXT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ack_o |=> (pc_o == PC_W'(EXT_VEC)) && stk_busy_o); // R10

    AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ack_o || ext_ack_o) |-> (!stk_busy_o && !clk_stop_o && !retire_i)); // R6

    AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tmr_ack_o, ext_ack_o})); // R11

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop_o && !wake) |=> clk_stop_o && $stable(pc_o) && $stable(stk_busy_o)); // R8

    AST_CALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !clk_stop_o && op_i == OP_CALL) |=> stk_busy_o && (pc_o == $past(tgt_i))); // R4

    AST_RET_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !clk_stop_o && (op_i == OP_RET || op_i == OP_RETI)) |=> !stk_busy_o); // R5
endmodule

// File: tb/tb_psq_flow_ctl.sv
module tb_psq_flow_ctl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        retire_i;
    logic [3:0]  op_i;
    logic        len2_i;
    logic [11:0] tgt_i;
    logic        carry_i;
    logic        tmr_flag_i;
    logic [7:0]  pins_i;
    logic [7:0]  wake_en_i;
    logic        bank_i;
    logic [12:0] fetch_addr_o;
    logic [11:0] pc_o;
    logic [11:0] stk_pc_o;
    logic        stk_c_o;
    logic        stk_busy_o;
    logic        carry_ld_o;
    logic        clk_stop_o;
    logic        tmr_ack_o;
    logic        ext_ack_o;

    int n_chk = 0;
    int n_bad = 0;
    logic s_tack, s_eack, s_cld, s_cval;
    logic [11:0] exp_pc;
    logic [11:0] saved;

    psq_flow_ctl dut (
        .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .op_i(op_i),
        .len2_i(len2_i), .tgt_i(tgt_i), .carry_i(carry_i),
        .tmr_flag_i(tmr_flag_i), .pins_i(pins_i), .wake_en_i(wake_en_i),
        .bank_i(bank_i), .fetch_addr_o(fetch_addr_o), .pc_o(pc_o),
        .stk_pc_o(stk_pc_o), .stk_c_o(stk_c_o), .stk_busy_o(stk_busy_o),
        .carry_ld_o(carry_ld_o), .clk_stop_o(clk_stop_o),
        .tmr_ack_o(tmr_ack_o), .ext_ack_o(ext_ack_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sample_and_step();
        #2;
        s_tack = tmr_ack_o;
        s_eack = ext_ack_o;
        s_cld  = carry_ld_o;
        s_cval = stk_c_o;
        @(posedge clk);
        #5;
    endtask

    task automatic run_op(input logic [3:0] op, input logic l2, input logic [11:0] tgt);
        retire_i = 1'b1;
        op_i     = op;
        len2_i   = l2;
        tgt_i    = tgt;
        sample_and_step();
        retire_i = 1'b0;
    endtask

    task automatic idle();
        retire_i = 1'b0;
        sample_and_step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; retire_i = 1'b0; op_i = 4'd0; len2_i = 1'b0; tgt_i = '0;
        carry_i = 1'b0; tmr_flag_i = 1'b0; pins_i = 8'hFF; wake_en_i = 8'h0F;
        bank_i = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 fetch", fetch_addr_o, 13'h1000);
        chk("R1 busy", stk_busy_o, 0);
        chk("R1 halt", clk_stop_o, 0);
        tmr_flag_i = 1'b1;
        idle();
        chk("R1 no ack while disabled", s_tack, 0);
        chk("R1 pc held", pc_o, 0);
        tmr_flag_i = 1'b0;

        // R2: sequential sweep with mixed lengths
        exp_pc = 12'h000;
        for (int i = 0; i < 40; i++) begin
            run_op(4'd0, (i % 3) == 0, 12'h000);
            exp_pc = exp_pc + (((i % 3) == 0) ? 12'd2 : 12'd1);
            chk("R2 advance", pc_o, exp_pc);
        end
        run_op(4'd1, 1'b1, 12'hFFE);
        run_op(4'd0, 1'b1, 12'h000);
        chk("R2 wrap", pc_o, 12'h000);
        chk("R2 bank", fetch_addr_o, 13'h1000);
        run_op(4'd1, 1'b1, 12'hFFF);
        run_op(4'd0, 1'b0, 12'h000);
        chk("R2 wrap by one", pc_o, 12'h000);

        // R3: jumps and conditional branches
        for (int i = 0; i < 16; i++) begin
            run_op(4'd1, 1'b1, 12'((i * 273) & 12'hFFF));
            chk("R3 jmp", pc_o, (i * 273) & 12'hFFF);
        end
        run_op(4'd1, 1'b1, 12'h800);
        run_op(4'd2, 1'b1, 12'h123);
        chk("R3 jcond keeps bit11 set", pc_o, 12'h923);
        run_op(4'd1, 1'b1, 12'h7FF);
        run_op(4'd2, 1'b1, 12'hFFF);
        chk("R3 jcond keeps bit11 clear", pc_o, 12'h7FF);

        // R4: call and return
        run_op(4'd1, 1'b1, 12'h345);
        run_op(4'd3, 1'b1, 12'h600);
        chk("R4 call target", pc_o, 12'h600);
        chk("R4 call push", stk_pc_o, 12'h347);
        chk("R4 busy", stk_busy_o, 1);
        run_op(4'd0, 1'b0, 12'h000);
        run_op(4'd4, 1'b0, 12'h000);
        chk("R4 ret no carry load", s_cld, 0);
        chk("R4 ret pc", pc_o, 12'h347);
        chk("R4 ret frees", stk_busy_o, 0);

        // R7 / R5: timer interrupt and return from it
        run_op(4'd6, 1'b0, 12'h000);
        chk("R6 ei advance", pc_o, 12'h348);
        carry_i = 1'b1; tmr_flag_i = 1'b1;
        idle();
        chk("R7 ack", s_tack, 1);
        chk("R7 vector", pc_o, 12'h004);
        chk("R7 bank kept", fetch_addr_o, 13'h1004);
        chk("R7 push pc", stk_pc_o, 12'h348);
        chk("R7 push carry", stk_c_o, 1);
        carry_i = 1'b0; tmr_flag_i = 1'b0;
        run_op(4'd5, 1'b0, 12'h000);
        chk("R5 carry load", s_cld, 1);
        chk("R5 carry value", s_cval, 1);
        chk("R5 pc", pc_o, 12'h348);

        // R6: deferral inside call, then under disable
        run_op(4'd3, 1'b1, 12'h200);
        tmr_flag_i = 1'b1;
        idle();
        chk("R6 held in call", s_tack, 0);
        chk("R6 pc unchanged", pc_o, 12'h200);
        chk("R6 return kept", stk_pc_o, 12'h34A);
        run_op(4'd4, 1'b0, 12'h000);
        chk("R6 ret pc", pc_o, 12'h34A);
        idle();
        chk("R6 taken after ret", s_tack, 1);
        chk("R6 vector", pc_o, 12'h004);
        tmr_flag_i = 1'b0;
        run_op(4'd5, 1'b0, 12'h000);
        run_op(4'd7, 1'b0, 12'h000);
        tmr_flag_i = 1'b1;
        idle();
        chk("R6 held while disabled", s_tack, 0);
        run_op(4'd6, 1'b0, 12'h000);
        chk("R6 ei no ack same cycle", s_tack, 0);
        idle();
        chk("R6 taken after ei", s_tack, 1);
        tmr_flag_i = 1'b0;
        run_op(4'd5, 1'b0, 12'h000);
        chk("R6 back", pc_o, 12'h34C);

        // R8 / R9: halt with interrupts disabled
        run_op(4'd7, 1'b0, 12'h000);
        run_op(4'd1, 1'b1, 12'h050);
        run_op(4'd8, 1'b0, 12'h000);
        chk("R8 halt pc", pc_o, 12'h051);
        chk("R8 clock stopped", clk_stop_o, 1);
        run_op(4'd1, 1'b1, 12'h777);
        chk("R8 retire ignored", pc_o, 12'h051);
        tmr_flag_i = 1'b1;
        idle();
        chk("R8 timer ignored", s_tack, 0);
        tmr_flag_i = 1'b0;
        pins_i = 8'h7F;
        idle();
        chk("R9 disabled pin no wake", clk_stop_o, 1);
        pins_i = 8'hFF;
        idle();
        chk("R9 rising no wake", clk_stop_o, 1);
        pins_i = 8'hFE;
        idle();
        chk("R9 woke", clk_stop_o, 0);
        chk("R9 resume pc", pc_o, 12'h051);
        idle();
        chk("R9 no wake irq", s_eack, 0);
        chk("R9 pc still", pc_o, 12'h051);
        pins_i = 8'hFF;
        idle();

        // R10: wake with interrupts enabled, bank 0
        run_op(4'd6, 1'b0, 12'h000);
        bank_i = 1'b0;
        run_op(4'd8, 1'b0, 12'h000);
        chk("R8 halt pc 2", pc_o, 12'h053);
        pins_i = 8'hFB;
        idle();
        chk("R10 woke", clk_stop_o, 0);
        idle();
        chk("R10 ext ack", s_eack, 1);
        chk("R10 vector", fetch_addr_o, 13'h0008);
        chk("R10 push", stk_pc_o, 12'h053);
        run_op(4'd5, 1'b0, 12'h000);
        chk("R10 back", pc_o, 12'h053);
        idle();
        chk("R10 request cleared", s_eack, 0);
        pins_i = 8'hFF;
        idle();

        // R12: edges while running do nothing
        pins_i = 8'hFE;
        idle();
        idle();
        chk("R12 no ext when running", s_eack, 0);
        chk("R12 pc", pc_o, 12'h053);
        pins_i = 8'hFF;
        idle();

        // R11: both pending, timer first
        run_op(4'd8, 1'b0, 12'h000);
        pins_i = 8'hFE;
        idle();
        tmr_flag_i = 1'b1;
        idle();
        chk("R11 timer first", s_tack, 1);
        chk("R11 ext waits", s_eack, 0);
        chk("R11 timer vector", pc_o, 12'h004);
        tmr_flag_i = 1'b0;
        run_op(4'd5, 1'b0, 12'h000);
        chk("R11 back", pc_o, 12'h054);
        idle();
        chk("R11 ext next", s_eack, 1);
        chk("R11 ext vector", pc_o, 12'h008);
        run_op(4'd5, 1'b0, 12'h000);
        chk("R11 final", pc_o, 12'h054);
        pins_i = 8'hFF;
        idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule